// File: doc/BRIEF.md
# Programmable GPIO Pin Bank

This block is one bank of general-purpose pins, up to 64 lines, seen by software through a small register read/write port. Software changes the output data latch only with atomic writes: writing to one register raises the lines whose data bits are 1, and writing to a second register drops them. Software never needs a read-modify-write of the whole output word. The current latch can be read back at either of these addresses. A read-only input word shows the pad levels after a two-flop synchronizer.

Each line has its own 64-bit configuration word with four fields:
- an output enable;
- a polarity inversion, applied to both the driven level and the sampled level;
- an open-drain mode, in which the line only ever pulls low and otherwise floats;
- a function selector. When the selector is non-zero, the line is handed to another function and the bank drives nothing on it.

The block feeds the pad ring with a level and an output enable for each line. Input filtering, interrupts and the pad cells themselves are outside this block.

Top module: `pinbank_ctl`

## Requirements
- R1: After reset is released, the output latch and every configuration word are zero, every pad output enable is 0, and every register reads as zero except the input word, which follows the pads.
- R2: A write to byte offset 0x8 sets exactly those latch bits whose data bit is 1. A read of 0x8 returns the latch, and the latch changes only on a write to 0x8 or 0x10. Data bits at or above NUM_LINES have no effect.
- R3: A write to byte offset 0x10 clears exactly those latch bits whose data bit is 1. Reading 0x10 also returns the latch.
- R4: The input word at offset 0x0 shows each pad level two clocks after it is sampled. Writes to 0x0 change nothing.
- R5: The configuration word of line N sits at offset 0x400 + 8*N. It keeps bit 0 (output enable), bit 1 (invert), bit 12 (open drain) and bits 25:16 (function select), and all other bits read as 0. Offsets for lines at or above NUM_LINES, and all other unmapped offsets, read 0 and ignore writes.
- R6: For a line in push-pull mode whose function select is zero, pad_out equals the latch bit XOR the invert bit, and pad_oe equals the output enable bit.
- R7: For a line in open-drain mode whose function select is zero, pad_out is 0. pad_oe is 1 only when output enable is 1 and (latch XOR invert) is 0.
- R8: When a line's function select is non-zero, its pad_out and pad_oe are both 0.
- R9: A read returns its data on rd_data in the next cycle. In every cycle that does not follow a read, rd_data is 0. The low three address bits are ignored.
- R10: The invert bit of a line also flips that line's bit in the input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid the cycle after a read |
| pad_in | input | NUM_LINES | Pad input levels (asynchronous) |
| pad_out | output | NUM_LINES | Level driven toward each pad |
| pad_oe | output | NUM_LINES | Output enable for each pad |

## Verification
The bench builds the bank with NUM_LINES = 40 and ADDR_W = 12. This leaves lines 40 to 63 unmapped, so the bench can check that set and clear data bits above the top line are dropped, and that configuration offsets past the last line read zero and ignore writes. A behavioural model tracks the latch, the configuration fields, the synchronizer stages and the read pipeline. The bench compares pad_out, pad_oe and rd_data against this model every cycle. Directed phases cover push-pull, open-drain with and without inversion, and function-select gating; a long random mix follows them.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int DATA_W   = 64;
  // Word (8-byte) offsets of the register regions
  localparam int WOFS_IN  = 0;
  localparam int WOFS_SET = 1;
  localparam int WOFS_CLR = 2;
  localparam int WOFS_CFG = 128; // byte offset 0x400
  // Configuration field positions
  localparam int CB_OE    = 0;
  localparam int CB_INV   = 1;
  localparam int CB_OD    = 12;
  localparam int CB_FLO   = 16;
  localparam int FUNC_W   = 10;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              od;
    logic              inv;
    logic              oe;
  } line_cfg_t;

  function automatic line_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
    line_cfg_t c;
    c.func = w[CB_FLO +: FUNC_W];
    c.od   = w[CB_OD];
    c.inv  = w[CB_INV];
    c.oe   = w[CB_OE];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_pack(input line_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_FLO +: FUNC_W] = c.func;
    w[CB_OD]  = c.od;
    w[CB_INV] = c.inv;
    w[CB_OE]  = c.oe;
    return w;
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_line.sv
module pinbank_line
  import pinbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  line_cfg_t         cfg_wr,
  input  logic              out_bit,
  input  logic              sync_bit,
  output logic [DATA_W-1:0] cfg_word,
  output logic              rx_bit,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              oe_en,
  output logic              od_mode
);
  line_cfg_t cfg_q, cfg_d;
  logic      drive_lvl;
  logic      gpio_own;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign gpio_own  = (cfg_q.func == '0);
  assign drive_lvl = out_bit ^ cfg_q.inv;

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (gpio_own) begin
      if (cfg_q.od) begin
        pad_oe = cfg_q.oe & ~drive_lvl;
      end else begin
        pad_out = drive_lvl;
        pad_oe  = cfg_q.oe;
      end
    end
  end

  assign rx_bit   = sync_bit ^ cfg_q.inv;
  assign cfg_word = cfg_pack(cfg_q);
  assign oe_en    = cfg_q.oe;
  assign od_mode  = cfg_q.od;
endmodule

// File: rtl/pinbank_regif.sv
module pinbank_regif
  import pinbank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [NUM_LINES-1:0]              rx_word,
  input  logic [NUM_LINES-1:0][DATA_W-1:0]  cfg_words,
  output logic [NUM_LINES-1:0]              dout_q,
  output logic [NUM_LINES-1:0]              cfg_we,
  output line_cfg_t                         cfg_wr,
  output logic [DATA_W-1:0]                 rd_data
);
  localparam int WA_W = ADDR_W - 3;

  logic [WA_W-1:0]      waddr;
  logic [WA_W-1:0]      cfg_idx;
  logic                 in_cfg;
  logic                 wr_set, wr_clr, rd_req;
  logic [NUM_LINES-1:0] dout_d;
  logic                 dout_en;
  logic [DATA_W-1:0]    rd_d;

  assign waddr   = req_addr[ADDR_W-1:3];
  assign cfg_idx = waddr - WA_W'(WOFS_CFG);
  assign in_cfg  = (waddr >= WA_W'(WOFS_CFG)) && (cfg_idx < WA_W'(NUM_LINES));
  assign wr_set  = req_valid && req_write && (waddr == WA_W'(WOFS_SET));
  assign wr_clr  = req_valid && req_write && (waddr == WA_W'(WOFS_CLR));
  assign rd_req  = req_valid && !req_write;
  assign cfg_wr  = cfg_unpack(req_wdata);

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_we
      assign cfg_we[i] = req_valid && req_write && in_cfg && (cfg_idx == WA_W'(i));
    end
  endgenerate

  // Output latch: next state
  always_comb begin
    dout_d  = dout_q;
    dout_en = wr_set || wr_clr;
    if (wr_set) dout_d = dout_q | req_wdata[NUM_LINES-1:0];
    if (wr_clr) dout_d = dout_q & ~req_wdata[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end

  // Read path: next state
  always_comb begin
    rd_d = '0;
    if (rd_req) begin
      if (waddr == WA_W'(WOFS_IN)) begin
        rd_d = DATA_W'(rx_word);
      end else if (waddr == WA_W'(WOFS_SET) || waddr == WA_W'(WOFS_CLR)) begin
        rd_d = DATA_W'(dout_q);
      end else if (in_cfg) begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (cfg_idx == WA_W'(i)) rd_d = cfg_words[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/pinbank_ctl.sv
module pinbank_ctl
  import pinbank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rd_data,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int SYNC_STAGES = 2;

  logic [1:0]                       rst_pipe_q;
  logic                             rst_sync_n;
  logic [NUM_LINES-1:0]             pad_sync;
  logic [NUM_LINES-1:0]             rx_word;
  logic [NUM_LINES-1:0]             dout_q;
  logic [NUM_LINES-1:0]             cfg_we;
  logic [NUM_LINES-1:0]             oe_vec;
  logic [NUM_LINES-1:0]             od_vec;
  logic [NUM_LINES-1:0][DATA_W-1:0] cfg_words;
  line_cfg_t                        cfg_wr;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pinbank_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  pinbank_regif #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rx_word   (rx_word),
    .cfg_words (cfg_words),
    .dout_q    (dout_q),
    .cfg_we    (cfg_we),
    .cfg_wr    (cfg_wr),
    .rd_data   (rd_data)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      pinbank_line u_line (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .cfg_we   (cfg_we[i]),
        .cfg_wr   (cfg_wr),
        .out_bit  (dout_q[i]),
        .sync_bit (pad_sync[i]),
        .cfg_word (cfg_words[i]),
        .rx_bit   (rx_word[i]),
        .pad_out  (pad_out[i]),
        .pad_oe   (pad_oe[i]),
        .oe_en    (oe_vec[i]),
        .od_mode  (od_vec[i])
      );
    end
  endgenerate
endmodule

// File: rtl/pinbank_ctl_chk.sv
module pinbank_ctl_chk #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [63:0]          req_wdata,
  input logic [63:0]          rd_data,
  input logic [NUM_LINES-1:0] dout_q,
  input logic [NUM_LINES-1:0] oe_vec,
  input logic [NUM_LINES-1:0] od_vec,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe
);
  logic                 set_wr, clr_wr;
  logic [NUM_LINES-1:0] wmask;

  assign set_wr = req_valid && req_write && (req_addr[ADDR_W-1:3] == (ADDR_W-3)'(1));
  assign clr_wr = req_valid && req_write && (req_addr[ADDR_W-1:3] == (ADDR_W-3)'(2));
  assign wmask  = req_wdata[NUM_LINES-1:0];

  assert_set_raises_only_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_wr |=> (dout_q == ($past(dout_q) | $past(wmask))));

  assert_clear_drops_only_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_wr |=> (dout_q == ($past(dout_q) & ~$past(wmask))));

  assert_latch_holds_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(set_wr || clr_wr) |=> $stable(dout_q));

  assert_oe_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_oe & ~oe_vec) == '0));

  assert_open_drain_low_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_out & od_vec) == '0));

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_valid && !req_write) |=> (rd_data == '0));
endmodule

bind pinbank_ctl pinbank_ctl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rd_data    (rd_data),
  .dout_q     (dout_q),
  .oe_vec     (oe_vec),
  .od_vec     (od_vec),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/test_pinbank_ctl.sv
module test_pinbank_ctl;
  localparam int LINES = 40;
  localparam int AW    = 12;
  localparam logic [63:0] LMASK = (64'd1 << LINES) - 64'd1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic [63:0]       rd_data;
  logic [LINES-1:0]  pad_in = '0;
  logic [LINES-1:0]  pad_out;
  logic [LINES-1:0]  pad_oe;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  always #2 clk = ~clk;

  pinbank_ctl #(.NUM_LINES(LINES), .ADDR_W(AW)) i_pinbank_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // ---------------- behavioural reference model ----------------
  logic [1:0]  m_rs;
  logic [63:0] m_dout, m_oe, m_inv, m_od, m_s1, m_s2, m_rd;
  int          m_func [64];

  function automatic logic [63:0] model_read(input logic [AW-1:0] a);
    int w;
    w = int'(a >> 3);
    if (w == 0) return (m_s2 ^ m_inv) & LMASK;
    if (w == 1 || w == 2) return m_dout;
    if (w >= 128 && w < 128 + LINES) begin
      int k;
      k = w - 128;
      return (64'(m_func[k]) << 16) | (64'(m_od[k]) << 12) | (64'(m_inv[k]) << 1) | 64'(m_oe[k]);
    end
    return 64'd0;
  endfunction

  task automatic model_clear();
    m_dout <= '0; m_oe <= '0; m_inv <= '0; m_od <= '0;
    m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
    for (int k = 0; k < 64; k++) m_func[k] <= 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= '0;
      model_clear();
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (!m_rs[1]) begin
        model_clear();
      end else begin
        m_s1 <= 64'(pad_in);
        m_s2 <= m_s1;
        m_rd <= (req_valid && !req_write) ? model_read(req_addr) : 64'd0;
        if (req_valid && req_write) begin
          int w;
          w = int'(req_addr >> 3);
          if (w == 1) m_dout <= m_dout | (req_wdata & LMASK);
          if (w == 2) m_dout <= m_dout & ~(req_wdata & LMASK);
          if (w >= 128 && w < 128 + LINES) begin
            int k;
            k = w - 128;
            m_oe[k]   <= req_wdata[0];
            m_inv[k]  <= req_wdata[1];
            m_od[k]   <= req_wdata[12];
            m_func[k] <= int'(req_wdata[25:16]);
          end
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic compare();
    logic [LINES-1:0] e_oe, e_out;
    for (int k = 0; k < LINES; k++) begin
      logic drv, gp;
      drv = m_dout[k] ^ m_inv[k];
      gp  = (m_func[k] == 0);
      e_oe[k]  = gp && m_oe[k] && (!m_od[k] || !drv);
      e_out[k] = gp && !m_od[k] && drv;
    end
    n_vec++;
    if (pad_oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s pad_oe actual %h expected %h at %0t", tag, pad_oe, e_oe, $time);
    end
    if (pad_out !== e_out) begin
      n_bad++;
      $display("FAIL %s pad_out actual %h expected %h at %0t", tag, pad_out, e_out, $time);
    end
    if (rd_data !== m_rd) begin
      n_bad++;
      $display("FAIL %s rd_data actual %h expected %h at %0t", tag, rd_data, m_rd, $time);
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b1, 1'b0, a, 64'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 64'd0);
  endtask

  function automatic logic [AW-1:0] cfg_a(input int line);
    return AW'(12'h400 + 8 * line);
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    tag = "R1";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    rd(12'h000); rd(12'h008); rd(12'h010); rd(cfg_a(0)); rd(cfg_a(39)); idle(2);

    tag = "R2";
    wr(12'h008, 64'h0000_0000_0000_00A5); rd(12'h008);
    wr(12'h008, 64'hFFFF_FF00_0000_0000); rd(12'h008);  // bits above line 39 dropped
    wr(12'h00C, 64'h0000_0000_0001_0000); rd(12'h00B);  // low address bits ignored
    idle(2);

    tag = "R5";
    wr(cfg_a(0), 64'h1);                // push-pull output
    wr(cfg_a(1), 64'h3);                // inverted output
    wr(cfg_a(2), 64'h1001);             // open drain
    wr(cfg_a(3), 64'h1003);             // open drain, inverted
    wr(cfg_a(5), 64'hFFFF_FFFF_FFFF_FFFF);
    wr(cfg_a(45), 64'h1);               // unmapped line
    wr(12'h020, 64'hFFFF);              // unmapped offset
    rd(cfg_a(0)); rd(cfg_a(3)); rd(cfg_a(5)); rd(cfg_a(45)); rd(12'h020); idle(2);

    tag = "R6";
    wr(12'h008, 64'h3); idle(2);
    wr(12'h010, 64'h1); idle(2);
    wr(cfg_a(39), 64'h1); wr(12'h008, 64'h80_0000_0000); idle(2);

    tag = "R7";
    wr(12'h010, 64'hC); idle(2);
    wr(12'h008, 64'h4); idle(2);
    wr(12'h008, 64'h8); idle(2);

    tag = "R8";
    wr(cfg_a(0), 64'h0005_0001); wr(12'h008, 64'h1); idle(2);
    wr(cfg_a(0), 64'h0000_0001); idle(2);

    tag = "R3";
    wr(12'h010, 64'hFFFF_FFFF_FFFF_FFF0); rd(12'h010);
    wr(12'h010, 64'hF); rd(12'h008); idle(2);

    tag = "R4";
    pad_in = 40'hA5_5A3C_C3F0;
    rd(12'h000); rd(12'h000); rd(12'h000); idle(1);
    wr(12'h000, 64'hFFFF_FFFF); rd(12'h000); idle(1);
    pad_in = 40'h00_FFFF_0000; idle(3); rd(12'h000); idle(1);

    tag = "R10";
    wr(cfg_a(1), 64'h2); wr(cfg_a(16), 64'h2); rd(12'h000); idle(1);

    tag = "R9";
    rd(cfg_a(1)); idle(1); step(1'b0, 1'b1, 12'h008, 64'hFF); idle(2);

    tag = "R2/R3/R5/R6/R7/R8/R10 mix";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [63:0] d;
      sel = int'($urandom_range(0, 9));
      if (sel < 2)      a = 12'h008;
      else if (sel < 4) a = 12'h010;
      else if (sel < 5) a = 12'h000;
      else if (sel < 6) a = AW'($urandom_range(0, 255)) << 3;
      else              a = cfg_a(int'($urandom_range(0, 47)));
      a = a | AW'($urandom_range(0, 7));
      d = {$urandom, $urandom};
      if (a >= 12'h400) begin
        d[25:16] = ($urandom_range(0, 3) == 0) ? d[25:16] : 10'd0;
      end
      if ($urandom_range(0, 7) == 0) pad_in = LINES'({$urandom, $urandom});
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d);
    end
    idle(4);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      finish_run();
    end
  end
endmodule